// File: doc/BRIEF.md
# SPI Load Fault Checker

This block is a host-side SPI master for one octal low-side driver that keeps the drive level of every load on its own and reports the voltage it sees on each output pin. A single `start` pulse, with a control byte, runs a full diagnosis. The byte is written to the driver and the bus goes idle for a settling interval, so that inrush currents decay and the driver's protection can act. The same byte is then written a second time, and the diagnostic byte that comes back during that second transfer is compared bit by bit with the byte that was sent.

A channel commanded ON (bit 0) whose pin still reads high has a shorted or overloaded load. A channel commanded OFF (bit 1) whose pin reads low has nothing pulling it up, which means an open load. The two flag vectors and a one-cycle `done` pulse are presented together when the second transfer ends. All bus timing (SCLK half period, CE lead and lag, settling gap) is set by parameters counted in system-clock cycles.

Top module: `spi_fault_checker`

## Requirements
- R1: While reset is held and after it is released with no start, `spi_ce_n` is 1, `spi_sclk` is 0, `busy` and `done` are 0 and both flag vectors are 0.
- R2: A start runs exactly two CE-low transfers of 8 SCLK cycles each. Each transfer shifts the latched control byte out on `spi_mosi` with bit 7 first, so the driver receives that byte both times.
- R3: `spi_mosi` changes only at SCLK rising edges or while SCLK is low, and never at a falling edge. `spi_miso` is sampled late in each SCLK high phase, and the first bit sampled becomes bit 7 of the readback.
- R4: `spi_sclk` is 0 whenever `spi_ce_n` is 1, and also in the cycles on both sides of every CE edge.
- R5: Each SCLK high phase and each SCLK low phase between bits lasts at least HALF_CYC clock cycles. The defaults give at least 200 ns per phase and at most 2 MHz at 50 MHz.
- R6: CE is low for at least LEAD_CYC cycles before the first SCLK rise, and stays low for at least LAG_CYC cycles after the last SCLK fall.
- R7: Between the two transfers of one start, CE stays high for at least SETTLE_CYC cycles.
- R8: `short_flags[i]` is 1 exactly when control bit i was 0 (ON) and readback bit i of the second transfer is 1.
- R9: `open_flags[i]` is 1 exactly when control bit i was 1 (OFF) and readback bit i of the second transfer is 0.
- R10: `busy` is 1 from the cycle after an accepted start until the cycle `done` is 1. `done` is high for exactly one cycle. The flags change only in that cycle and hold their values at all other times.
- R11: A start that arrives while `busy` is 1 is ignored: the control byte in use and the number of transfers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a diagnosis; sampled only when idle |
| ctrl_byte | input | DATA_W | Control byte, 0 = channel ON, 1 = OFF |
| spi_ce_n | output | 1 | Active-low chip enable to the driver |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the driver |
| spi_miso | input | 1 | Diagnostic data from the driver |
| busy | output | 1 | A diagnosis is in progress |
| done | output | 1 | One-cycle pulse when the flags are updated |
| short_flags | output | DATA_W | Per-channel short/overload flag |
| open_flags | output | DATA_W | Per-channel open-load flag |

## Verification
The bench targets single-channel faults on bit 7 and on bit 0. A design that reversed the shift direction, or sampled MISO one edge late, would report the fault on the wrong channel or lose it. Start pulses are sent during the first transfer and again during the settling gap. A design that accepted them would write the second control byte, run a third transfer, or return flags for the wrong byte. The checks also cover CE lead, lag and gap timing and the SCLK phase lengths, so a divider that is off by one cycle, or an SCLK edge placed next to a CE edge, is caught. Flags are checked again in the middle of the next run, so a design that cleared or updated them early is caught as well.

// File: rtl/sfc_pkg.sv
// Shared state types for the SPI load fault checker.
package sfc_pkg;

    // Phases of one byte transfer on the SPI pins.
    typedef enum logic [2:0] {
        XF_IDLE,
        XF_LEAD,
        XF_HIGH,
        XF_LOW,
        XF_LAG
    } xfer_state_t;

    // Phases of the write / settle / rewrite sequence.
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PASS1,
        SQ_SETTLE,
        SQ_PASS2
    } seq_state_t;

endpackage

// File: rtl/sfc_byte_xfer.sv
// One SPI byte transfer in mode with SCLK idle low.
// CE falls, and after LEAD_CYC cycles SCLK rises. Each bit takes HALF_CYC
// cycles high, then HALF_CYC cycles low. MOSI changes at the rising edges
// so the slave can sample it on the falling edges. MISO passes through
// SYNC_STAGES flops and is sampled in the last cycle of each high phase.
// CE rises LAG_CYC cycles after the low phase that follows the last bit.
// Assumes HALF_CYC > SYNC_STAGES + 1, LEAD_CYC >= 1, LAG_CYC >= 1, W >= 2.
module sfc_byte_xfer
    import sfc_pkg::*;
#(
    parameter int W           = 8,
    parameter int HALF_CYC    = 13,
    parameter int LEAD_CYC    = 13,
    parameter int LAG_CYC     = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] tx_byte,
    output logic [W-1:0] rx_byte,
    output logic         xfer_done,
    output logic         spi_ce_n,
    output logic         spi_sclk,
    output logic         spi_mosi,
    input  logic         spi_miso
);

    localparam int MAXC = (HALF_CYC > LEAD_CYC) ?
                          ((HALF_CYC > LAG_CYC) ? HALF_CYC : LAG_CYC) :
                          ((LEAD_CYC > LAG_CYC) ? LEAD_CYC : LAG_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam int BW = $clog2(W);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);
    localparam logic [CW-1:0] LAG_LAST  = CW'(LAG_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(W - 1);

    xfer_state_t   state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bit_idx;
    logic [W-1:0]  tx_sr;
    logic [W-1:0]  rx_sr;
    logic          miso_s;

    // MISO synchronizer; the number of stages picks the variant.
    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            assign miso_s = spi_miso;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] pipe;
            logic [SYNC_STAGES:0]   pipe_n;
            always_comb pipe_n = {pipe, spi_miso};
            // Shift MISO through the synchronizer flops.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= pipe_n[SYNC_STAGES-1:0];
            end
            assign miso_s = pipe[SYNC_STAGES-1];
        end
    endgenerate

    // Transfer sequencer: CE lead, eight SCLK periods, CE lag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= XF_IDLE;
            cnt       <= '0;
            bit_idx   <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            spi_ce_n  <= 1'b1;
            spi_sclk  <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            case (state)
                XF_IDLE: begin
                    if (go) begin
                        spi_ce_n <= 1'b0;
                        tx_sr    <= tx_byte;
                        cnt      <= '0;
                        bit_idx  <= '0;
                        state    <= XF_LEAD;
                    end
                end
                XF_LEAD: begin
                    if (cnt == LEAD_LAST) begin
                        cnt      <= '0;
                        spi_sclk <= 1'b1;
                        state    <= XF_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XF_HIGH: begin
                    if (cnt == HALF_LAST) begin
                        cnt      <= '0;
                        spi_sclk <= 1'b0;
                        rx_sr    <= {rx_sr[W-2:0], miso_s};
                        state    <= XF_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XF_LOW: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        if (bit_idx == BIT_LAST) begin
                            state <= XF_LAG;
                        end else begin
                            bit_idx  <= bit_idx + 1'b1;
                            tx_sr    <= {tx_sr[W-2:0], 1'b0};
                            spi_sclk <= 1'b1;
                            state    <= XF_HIGH;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                XF_LAG: begin
                    if (cnt == LAG_LAST) begin
                        cnt       <= '0;
                        spi_ce_n  <= 1'b1;
                        tx_sr     <= '0;
                        xfer_done <= 1'b1;
                        state     <= XF_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    assign spi_mosi = tx_sr[W-1];
    assign rx_byte  = rx_sr;

    // ---------------- assertions ----------------
    logic [CW:0] lvl_run;
    logic        sclk_seen;

    // Checker: counts how long SCLK has held its current level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_run   <= '0;
            sclk_seen <= 1'b0;
        end else if (spi_sclk != sclk_seen) begin
            lvl_run   <= 1;
            sclk_seen <= spi_sclk;
        end else if (lvl_run != '1) begin
            lvl_run <= lvl_run + 1'b1;
        end
    end

    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_ce_n |-> !spi_sclk);

    // R4
    ce_edge_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_ce_n != $past(spi_ce_n)) |-> (!spi_sclk && !$past(spi_sclk)));

    // R3
    mosi_hold_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_sclk) && !spi_sclk) |-> (spi_mosi == $past(spi_mosi)));

    // R5
    sclk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_sclk && sclk_seen) |-> (lvl_run >= (CW+1)'(HALF_CYC)));

endmodule

// File: rtl/sfc_seq.sv
// Write / settle / rewrite sequencer.
// An accepted start latches the control byte and launches the first
// transfer. After that transfer it waits SETTLE_CYC cycles, then launches
// the second transfer with the same byte. The end of the second transfer
// raises `capture` for one cycle, and `done` follows as a registered pulse.
// A start that arrives while busy is ignored.
// Assumes that `xfer_done` comes only from a transfer this block launched.
module sfc_seq
    import sfc_pkg::*;
#(
    parameter int W          = 8,
    parameter int SETTLE_CYC = 8000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] ctrl_byte,
    input  logic         xfer_done,
    output logic         go,
    output logic [W-1:0] tx_byte,
    output logic         capture,
    output logic         done,
    output logic         busy
);

    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    seq_state_t    state;
    logic [SW-1:0] wait_cnt;
    logic [W-1:0]  ctrl_q;

    // Step through pass 1, the settling wait and pass 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            wait_cnt <= '0;
            ctrl_q   <= '0;
            go       <= 1'b0;
            done     <= 1'b0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        ctrl_q <= ctrl_byte;
                        go     <= 1'b1;
                        state  <= SQ_PASS1;
                    end
                end
                SQ_PASS1: begin
                    if (xfer_done) begin
                        wait_cnt <= '0;
                        state    <= SQ_SETTLE;
                    end
                end
                SQ_SETTLE: begin
                    if (wait_cnt == SETTLE_LAST) begin
                        go    <= 1'b1;
                        state <= SQ_PASS2;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                SQ_PASS2: begin
                    if (xfer_done) begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign capture = (state == SQ_PASS2) && xfer_done;
    assign busy    = (state != SQ_IDLE);
    assign tx_byte = ctrl_q;

    // ---------------- assertions ----------------
    // R11
    ctrl_frozen_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(tx_byte));

    // R10
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/sfc_fault_decode.sv
// Per-channel fault classification.
// Compares the control byte that was sent with the byte read back.
// A channel sent ON (0) that reads high is a short or overload.
// A channel sent OFF (1) that reads low is an open load.
// Purely combinational; the caller registers the result.
module sfc_fault_decode #(
    parameter int W = 8
) (
    input  logic [W-1:0] sent,
    input  logic [W-1:0] back,
    output logic [W-1:0] short_vec,
    output logic [W-1:0] open_vec
);

    // One comparator pair per channel.
    generate
        for (genvar i = 0; i < W; i++) begin : g_ch
            assign short_vec[i] = ~sent[i] &  back[i];
            assign open_vec[i]  =  sent[i] & ~back[i];
        end
    endgenerate

endmodule

// File: rtl/spi_fault_checker.sv
// SPI load fault checker, top level.
// Ties the sequencer, the byte transfer engine and the fault decoder
// together. The flag registers load only on the capture strobe at the end
// of the second transfer, in the same cycle that `done` pulses.
// Assumes one driver on the bus and MISO that is valid while SCLK is high.
module spi_fault_checker #(
    parameter int DATA_W      = 8,
    parameter int HALF_CYC    = 13,
    parameter int LEAD_CYC    = 13,
    parameter int LAG_CYC     = 13,
    parameter int SETTLE_CYC  = 8000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] ctrl_byte,
    output logic              spi_ce_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] short_flags,
    output logic [DATA_W-1:0] open_flags
);

    logic              go;
    logic              xfer_done;
    logic              capture;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] dec_short;
    logic [DATA_W-1:0] dec_open;

    sfc_seq #(
        .W          (DATA_W),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctrl_byte (ctrl_byte),
        .xfer_done (xfer_done),
        .go        (go),
        .tx_byte   (tx_byte),
        .capture   (capture),
        .done      (done),
        .busy      (busy)
    );

    sfc_byte_xfer #(
        .W           (DATA_W),
        .HALF_CYC    (HALF_CYC),
        .LEAD_CYC    (LEAD_CYC),
        .LAG_CYC     (LAG_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .xfer_done (xfer_done),
        .spi_ce_n  (spi_ce_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    sfc_fault_decode #(
        .W (DATA_W)
    ) u_dec (
        .sent      (tx_byte),
        .back      (rx_byte),
        .short_vec (dec_short),
        .open_vec  (dec_open)
    );

    // Load the fault flags at the end of the second transfer only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_flags <= '0;
            open_flags  <= '0;
        end else if (capture) begin
            short_flags <= dec_short;
            open_flags  <= dec_open;
        end
    end

    // ---------------- assertions ----------------
    localparam int HW = $clog2(SETTLE_CYC + 4) + 1;

    logic [HW-1:0] ce_hi_run;
    logic          ce_prev;
    logic          pass1_seen;

    // Checker: length of the CE-high gap, and whether pass 1 has ended.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_hi_run  <= '0;
            ce_prev    <= 1'b1;
            pass1_seen <= 1'b0;
        end else begin
            ce_prev <= spi_ce_n;
            if (!spi_ce_n)            ce_hi_run <= '0;
            else if (ce_hi_run != '1) ce_hi_run <= ce_hi_run + 1'b1;
            if (spi_ce_n && !ce_prev) pass1_seen <= 1'b1;
            else if (!busy)           pass1_seen <= 1'b0;
        end
    end

    // R7
    settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_prev && !spi_ce_n && pass1_seen) |-> (ce_hi_run >= HW'(SETTLE_CYC)));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(short_flags) && $stable(open_flags)));

    // R8 R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((short_flags & open_flags) == '0));

endmodule

// File: tb/spi_fault_checker_test.sv
`timescale 1ns/1ps
module spi_fault_checker_test;

    localparam int HALF   = 13;
    localparam int LEAD   = 13;
    localparam int LAG    = 13;
    localparam int SETTLE = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] ctrl = 8'h00;
    logic       ce_n, sclk, mosi;
    logic       miso = 1'b0;
    logic       busy, done;
    logic [7:0] sflags, oflags;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    spi_fault_checker #(
        .DATA_W(8), .HALF_CYC(HALF), .LEAD_CYC(LEAD), .LAG_CYC(LAG),
        .SETTLE_CYC(SETTLE), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_byte(ctrl),
        .spi_ce_n(ce_n), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
        .busy(busy), .done(done), .short_flags(sflags), .open_flags(oflags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        n_cmp++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
        end
    endtask

    // ---------- driver model: loads with injected faults ----------
    logic [7:0] f_short = 8'h00;
    logic [7:0] f_open  = 8'h00;
    logic [7:0] s_sr    = 8'h00;
    logic [7:0] s_latch = 8'hFF;
    int s_bits = 0, s_bits_last = 0, ce_falls = 0;

    // Pin level: a short pulls high, an open pulls low, else follows the latch.
    function automatic logic [7:0] pin_level(logic [7:0] lat, logic [7:0] fs, logic [7:0] fo);
        return fs | (lat & ~fo);
    endfunction

    function automatic logic [7:0] exp_short(logic [7:0] c, logic [7:0] fs, logic [7:0] fo);
        logic [7:0] rb;
        rb = pin_level(c, fs, fo);
        return ~c & rb;
    endfunction

    function automatic logic [7:0] exp_open(logic [7:0] c, logic [7:0] fs, logic [7:0] fo);
        logic [7:0] rb;
        rb = pin_level(c, fs, fo);
        return c & ~rb;
    endfunction

    always @(negedge ce_n) begin
        s_sr = pin_level(s_latch, f_short, f_open);
        s_bits = 0;
        ce_falls++;
    end
    always @(posedge sclk) if (ce_n === 1'b0) miso = s_sr[7];
    always @(negedge sclk) if (ce_n === 1'b0) begin
        s_sr = {s_sr[6:0], mosi};
        s_bits++;
    end
    always @(posedge ce_n) if (s_bits > 0) begin
        s_latch = s_sr;
        s_bits_last = s_bits;
    end

    // ---------- bus timing monitor ----------
    bit   mon_en = 1'b0;
    logic ce_q = 1'b1, sclk_q = 1'b0;
    int   ce_run = 0, sclk_run = 0, since_fall = 0, pcount = 0;
    bit   first_rise = 1'b0;

    always @(negedge clk) if (mon_en) begin
        if (sclk !== sclk_q) begin
            chk("R4 SCLK toggles only with CE low", {31'd0, ce_n}, 0);
            if (sclk) begin
                if (first_rise) chk_ge("R6 CE lead before first SCLK rise", ce_run, LEAD);
                else            chk_ge("R5 SCLK low phase", sclk_run, HALF);
                first_rise = 1'b0;
            end else begin
                chk_ge("R5 SCLK high phase", sclk_run, HALF);
                since_fall = 0;
            end
            sclk_run = 1;
        end else begin
            sclk_run++;
        end
        since_fall++;
        if (ce_n !== ce_q) begin
            chk("R4 SCLK low at CE edge", {30'd0, sclk, sclk_q}, 0);
            if (ce_n === 1'b0) begin
                if (pcount % 2 == 1) chk_ge("R7 settle gap between passes", ce_run, SETTLE);
                pcount++;
                first_rise = 1'b1;
            end else begin
                chk_ge("R6 CE lag after last SCLK fall", since_fall, LAG);
            end
            ce_run = 1;
        end else begin
            ce_run++;
        end
        ce_q   = ce_n;
        sclk_q = sclk;
    end

    // ---------- stimulus ----------
    task automatic pulse_start(input logic [7:0] c);
        @(negedge clk);
        ctrl  = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_checks(input logic [7:0] c, input logic [7:0] fs,
                                 input logic [7:0] fo, input string tag, input int falls0);
        while (done !== 1'b1) @(negedge clk);
        chk({"R8 short flags ", tag}, sflags, exp_short(c, fs, fo));
        chk({"R9 open flags ", tag}, oflags, exp_open(c, fs, fo));
        chk({"R2 driver latched control byte ", tag}, s_latch, c);
        chk({"R2 bits per transfer ", tag}, s_bits_last, 8);
        chk({"R2 two transfers per start ", tag}, ce_falls - falls0, 2);
        chk({"R10 busy low with done ", tag}, busy, 0);
        @(negedge clk);
        chk({"R10 done lasts one cycle ", tag}, done, 0);
    endtask

    task automatic run_case(input logic [7:0] c, input logic [7:0] fs,
                            input logic [7:0] fo, input string tag);
        int falls0;
        falls0  = ce_falls;
        f_short = fs;
        f_open  = fo;
        pulse_start(c);
        chk({"R10 busy after start ", tag}, busy, 1);
        finish_checks(c, fs, fo, tag, falls0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int falls0;
        int extra_done;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1: state while reset is held
        chk("R1 CE high in reset", ce_n, 1);
        chk("R1 SCLK low in reset", sclk, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 CE idle high", ce_n, 1);
        chk("R1 SCLK idle low", sclk, 0);
        chk("R1 busy idle", busy, 0);
        chk("R1 done idle", done, 0);
        chk("R1 flags clear", {sflags, oflags}, 0);

        // Directed cases
        run_case(8'h00, 8'h00, 8'h00, "all on healthy");
        run_case(8'hFF, 8'h00, 8'h00, "all off healthy");
        run_case(8'h00, 8'hFF, 8'h00, "all on shorted");
        run_case(8'hFF, 8'h00, 8'hFF, "all off open");
        run_case(8'h00, 8'h80, 8'h00, "R3 ch7 short");
        run_case(8'h00, 8'h01, 8'h00, "R3 ch0 short");
        run_case(8'hFF, 8'h00, 8'h80, "R3 ch7 open");
        run_case(8'hFF, 8'h00, 8'h01, "R3 ch0 open");
        run_case(8'hA5, 8'h5A, 8'hA5, "mixed both kinds");
        run_case(8'h3C, 8'hC3, 8'h3C, "faults on unmatched command");

        // R10: flags hold their old value during the next run
        f_short = 8'h00;
        f_open  = 8'h00;
        falls0 = ce_falls;
        pulse_start(8'h00);
        repeat (400) @(negedge clk);
        chk("R10 short flags held mid-run", sflags, exp_short(8'h3C, 8'hC3, 8'h3C));
        chk("R10 open flags held mid-run", oflags, exp_open(8'h3C, 8'hC3, 8'h3C));
        finish_checks(8'h00, 8'h00, 8'h00, "after hold", falls0);

        // R11: start while busy is ignored (in pass 1 and in the settle gap)
        f_short = 8'h21;
        f_open  = 8'h84;
        falls0 = ce_falls;
        pulse_start(8'h96);
        repeat (100) @(negedge clk);
        pulse_start(8'h69);
        repeat (250) @(negedge clk);
        pulse_start(8'h0F);
        finish_checks(8'h96, 8'h21, 8'h84, "R11 start while busy", falls0);
        falls0 = ce_falls;
        extra_done = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (done === 1'b1) extra_done++;
        end
        chk("R11 no transfer after ignored start", ce_falls - falls0, 0);
        chk("R11 no extra done", extra_done, 0);

        // Random cases
        for (int i = 0; i < 14; i++) begin
            logic [7:0] c, fs, fo;
            c  = 8'($urandom);
            fs = 8'($urandom);
            fo = 8'($urandom) & ~fs;
            run_case(c, fs, fo, "random");
        end

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule